// File: doc/BRIEF.md
# Chainable Converter Serial Port

This block is the device-side serial port of a data converter that may sit in a daisy-chained SPI string. During a frame it shifts its own conversion word out on SDO. At the same time it captures every bit that arrives on SDI. Once its own bits have all been sent, SDO carries the bits received on SDI, delayed by exactly one frame. This lets the next device in the string receive them. Every device shares one SCLK, so all ports in the string advance together.

Chip select is active low. When it rises, the port takes the trailing frame-length bits it received as the command frame and presents it. The command frame is one pad byte, then a 16-bit command word, then any remaining tail bits. The frame length is chosen with `fmt_sel` and can be 24, 32 or 40 bits. The serial pins are sampled with the system clock through synchronizers. SCLK must therefore run well below the system clock: each half period must cover at least six system clocks.

Top module: `dcp_port`

## Requirements
- R1: After reset, `spi_sdo` is 0, `cmd_valid` is 0, `cmd_pad`, `cmd_op` and `cmd_tail` are all zero, and the held conversion word is zero.
- R2: The frame length L is taken from `fmt_sel` when chip select falls. The encoding is 2'b00 → 24 bits, 2'b01 → 32 bits, 2'b10 → 40 bits, and 2'b11 → 24 bits.
- R3: Once chip select is low, `spi_sdo` shows bit 39 of the held word before the first SCLK rising edge. It then advances by one bit after each SCLK falling edge, MSB first, through bits 39 down to 40−L.
- R4: In bit period i (0-based, counted from chip-select fall) with i ≥ L, `spi_sdo` equals the SDI bit sampled at rising edge i−L+1.
- R5: SDI is sampled on SCLK rising edges only.
- R6: When chip select rises after at least L rising edges, `cmd_valid` pulses. The last L sampled bits are placed left-aligned in a 40-bit window, oldest bit at bit 39. The outputs are `cmd_pad` = window[39:32], `cmd_op` = window[31:16] and `cmd_tail` = window[15:0].
- R7: When chip select rises after fewer than L rising edges, there is no `cmd_valid` pulse and the three command fields keep their previous values.
- R8: When more than L clocks are applied, only the final L received bits are decoded.
- R9: `conv_load` copies `conv_word` into the held word only while chip select is high. A load while chip select is low has no effect.
- R10: While chip select is high, `spi_sdo` is 0.
- R11: `cmd_valid` never stays high for more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select; its rising edge ends a frame |
| spi_sdi | input | 1 | Serial data in, from the host or the upstream device |
| spi_sdo | output | 1 | Serial data out: own frame, then forwarded SDI |
| fmt_sel | input | 2 | Frame length select |
| conv_word | input | 40 | Conversion word; the frame uses its top L bits |
| conv_load | input | 1 | Strobe that copies conv_word into the held word |
| cmd_valid | output | 1 | One-cycle pulse when a command frame is decoded |
| cmd_pad | output | 8 | Leading pad byte of the decoded frame |
| cmd_op | output | 16 | Two command bytes of the decoded frame |
| cmd_tail | output | 16 | Bits after the command, left-aligned, zero-filled |

## Verification
The main function is driven with frames of exactly 24, 32 and 40 clocks in every encoding of `fmt_sel`, including the alias 2'b11. This separates the three frame lengths and the alias. A 72-clock frame, which stands for three chained devices, shows whether forwarded bits arrive one frame late and whether only the trailing window is decoded. A 16-clock frame shows that an incomplete frame does not decode. A load pulse during a frame, followed by a second frame, shows whether that load could corrupt the outgoing word.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int FRAME_MAX = 40;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);
  localparam int PAD_W     = 8;
  localparam int OP_W      = 16;
  localparam int TAIL_W    = FRAME_MAX - PAD_W - OP_W;

  typedef enum logic [1:0] {
    FMT_SHORT = 2'b00,
    FMT_MID   = 2'b01,
    FMT_LONG  = 2'b10,
    FMT_ALIAS = 2'b11
  } fmt_e;

  // frame length in bits for a format code
  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] sel);
    case (fmt_e'(sel))
      FMT_MID:  return LEN_W'(32);
      FMT_LONG: return LEN_W'(40);
      default:  return LEN_W'(24);
    endcase
  endfunction

  // ones in the top len bits
  function automatic logic [FRAME_MAX-1:0] lead_mask(input logic [LEN_W-1:0] len);
    return ~({FRAME_MAX{1'b1}} >> len);
  endfunction

  // move the low len bits to the top
  function automatic logic [FRAME_MAX-1:0] left_align(input logic [FRAME_MAX-1:0] v,
                                                      input logic [LEN_W-1:0] len);
    return v << (FRAME_MAX - int'(len));
  endfunction

  // one falling-edge step: shift left, insert the forwarded bit at the frame floor
  function automatic logic [FRAME_MAX-1:0] tx_advance(input logic [FRAME_MAX-1:0] sr,
                                                      input logic [LEN_W-1:0] len,
                                                      input logic b);
    logic [FRAME_MAX-1:0] n;
    logic [LEN_W-1:0] pos;
    n      = sr << 1;
    pos    = LEN_W'(FRAME_MAX) - len;
    n[pos] = b;
    return n;
  endfunction
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcp_tx.sv
module dcp_tx
  import dcp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 fall_i,
  input  logic                 act_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [FRAME_MAX-1:0] word_i,
  input  logic                 fwd_bit_i,
  output logic                 sdo_o
);
  logic [FRAME_MAX-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sr_q <= '0;
    else if (start_i)          sr_q <= word_i & lead_mask(len_i);
    else if (fall_i && act_i)  sr_q <= tx_advance(sr_q, len_i, fwd_bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sdo_o <= 1'b0;
    else if (!act_i) sdo_o <= 1'b0;
    else             sdo_o <= sr_q[FRAME_MAX-1];
  end

  // R10: output is quiet whenever chip select is high
  assert_sdo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> !sdo_o);
endmodule

// File: rtl/dcp_rx.sv
module dcp_rx
  import dcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rise_i,
  input  logic              act_i,
  input  logic              end_i,
  input  logic              sdi_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              last_o,
  output logic              cmd_valid_o,
  output logic [PAD_W-1:0]  pad_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAIL_W-1:0] tail_o
);
  logic [FRAME_MAX-1:0] sr_q;
  logic [LEN_W-1:0]     cnt_q;
  logic [FRAME_MAX-1:0] window;
  logic                 enough;

  assign window = left_align(sr_q, len_i);
  assign enough = (cnt_q >= len_i);
  assign last_o = sr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (rise_i && act_i) begin
      sr_q  <= {sr_q[FRAME_MAX-2:0], sdi_i};
      cnt_q <= (cnt_q == LEN_W'(FRAME_MAX)) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      pad_o       <= '0;
      op_o        <= '0;
      tail_o      <= '0;
    end else if (end_i && enough) begin
      cmd_valid_o <= 1'b1;
      pad_o       <= window[FRAME_MAX-1 -: PAD_W];
      op_o        <= window[FRAME_MAX-PAD_W-1 -: OP_W];
      tail_o      <= window[TAIL_W-1:0];
    end else begin
      cmd_valid_o <= 1'b0;
    end
  end

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  assert_valid_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(end_i));
  assert_short_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && (cnt_q < len_i)) |=> (!cmd_valid_o && $stable(op_o) && $stable(pad_o)));
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && act_i && !start_i && (cnt_q < LEN_W'(FRAME_MAX))) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dcp_port.sv
module dcp_port
  import dcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_sdi,
  output logic        spi_sdo,
  input  logic [1:0]  fmt_sel,
  input  logic [39:0] conv_word,
  input  logic        conv_load,
  output logic        cmd_valid,
  output logic [7:0]  cmd_pad,
  output logic [15:0] cmd_op,
  output logic [15:0] cmd_tail
);
  logic s_sclk, s_cs_n, s_sdi;
  logic sclk_d, cs_d;
  logic sclk_rise, sclk_fall, frame_start, frame_end, frame_act;
  logic [LEN_W-1:0]     len_q, len_use;
  logic [FRAME_MAX-1:0] hold_q;
  logic                 fwd_bit;

  dcp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk, spi_cs_n, spi_sdi}),
    .q     ({s_sclk, s_cs_n, s_sdi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= s_sclk;
      cs_d   <= s_cs_n;
    end
  end

  // named internal events
  assign sclk_rise   = s_sclk & ~sclk_d;
  assign sclk_fall   = ~s_sclk & sclk_d;
  assign frame_start = ~s_cs_n & cs_d;
  assign frame_end   = s_cs_n & ~cs_d;
  assign frame_act   = ~s_cs_n;
  assign len_use     = frame_start ? frame_len(fmt_sel) : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           len_q <= LEN_W'(24);
    else if (frame_start) len_q <= frame_len(fmt_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hold_q <= '0;
    else if (conv_load && s_cs_n) hold_q <= conv_word;
  end

  dcp_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (frame_start),
    .fall_i    (sclk_fall),
    .act_i     (frame_act),
    .len_i     (len_use),
    .word_i    (hold_q),
    .fwd_bit_i (fwd_bit),
    .sdo_o     (spi_sdo)
  );

  dcp_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (frame_start),
    .rise_i      (sclk_rise),
    .act_i       (frame_act),
    .end_i       (frame_end),
    .sdi_i       (s_sdi),
    .len_i       (len_q),
    .last_o      (fwd_bit),
    .cmd_valid_o (cmd_valid),
    .pad_o       (cmd_pad),
    .op_o        (cmd_op),
    .tail_o      (cmd_tail)
  );

  // R9: the held word cannot change while a frame is in progress
  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_load && !s_cs_n) |=> $stable(hold_q));
  // R2: only legal lengths are latched
  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (len_q == 6'd24 || len_q == 6'd32 || len_q == 6'd40));
endmodule

// File: tb/dcp_port_tb.sv
module dcp_port_tb;
  localparam int HP = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, spi_sclk, spi_cs_n, spi_sdi, spi_sdo, conv_load, cmd_valid;
  logic [1:0]  fmt_sel;
  logic [39:0] conv_word;
  logic [7:0]  cmd_pad;
  logic [15:0] cmd_op, cmd_tail;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int sdi_q[$];
  logic [39:0] cur_word;
  logic [7:0]  e_pad;
  logic [15:0] e_op, e_tail;

  dcp_port u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .fmt_sel(fmt_sel), .conv_word(conv_word),
    .conv_load(conv_load), .cmd_valid(cmd_valid), .cmd_pad(cmd_pad),
    .cmd_op(cmd_op), .cmd_tail(cmd_tail)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_check(input int n);
    repeat (n) begin
      @(negedge clk);
      chk("R10 sdo low while deselected", spi_sdo, 0);
    end
  endtask

  task automatic load(input logic [39:0] w);
    conv_word = w; conv_load = 1'b1;
    @(negedge clk);
    conv_load = 1'b0;
    cur_word  = w;
    idle_check(6);
  endtask

  task automatic fill(input logic [127:0] pat, input int n);
    sdi_q.delete();
    for (int k = 0; k < n; k++) sdi_q.push_back(int'(pat[127-k]));
  endtask

  function automatic int flen(input logic [1:0] m);
    return (m == 2'b01) ? 32 : (m == 2'b10) ? 40 : 24;
  endfunction

  task automatic frame(input logic [1:0] m, input int n, input int load_at,
                       input logic [39:0] mid_word, input string own_tag);
    int L;
    int pulses;
    logic [39:0] exp40;
    L = flen(m);
    pulses = 0;
    fmt_sel = m;
    @(negedge clk);
    spi_cs_n = 1'b0; spi_sdi = sdi_q[0][0];
    tick(HP);
    for (int i = 0; i < n; i++) begin
      logic eb;
      eb = (i < L) ? cur_word[39-i] : sdi_q[i-L][0];
      chk((i < L) ? own_tag : "R4 forwarded bit", spi_sdo, eb);
      spi_sclk = 1'b1;
      tick(HP);
      if (i == load_at) begin conv_word = mid_word; conv_load = 1'b1; end
      spi_sclk = 1'b0;
      if (i + 1 < n) spi_sdi = sdi_q[i+1][0];
      tick(1);
      conv_load = 1'b0;
      tick(HP - 1);
    end
    spi_cs_n = 1'b1; spi_sdi = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (cmd_valid) pulses++;
    end
    if (n >= L) begin
      exp40 = '0;
      for (int k = 0; k < L; k++) exp40[39-k] = sdi_q[n-L+k][0];
      e_pad = exp40[39:32]; e_op = exp40[31:16]; e_tail = exp40[15:0];
      chk("R11 one decode pulse", pulses, 1);
      chk((n > L) ? "R8 trailing pad byte" : "R6 pad byte", cmd_pad, e_pad);
      chk((n > L) ? "R8 trailing command" : "R5 R6 command word", cmd_op, e_op);
      chk("R6 tail bits", cmd_tail, e_tail);
    end else begin
      chk("R7 no pulse on short frame", pulses, 0);
      chk("R7 pad kept", cmd_pad, e_pad);
      chk("R7 command kept", cmd_op, e_op);
      chk("R7 tail kept", cmd_tail, e_tail);
    end
    idle_check(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_sdi = 1'b0;
    fmt_sel = 2'b00; conv_word = '0; conv_load = 1'b0;
    cur_word = '0; e_pad = '0; e_op = '0; e_tail = '0;
    tick(5);
    chk("R1 sdo after reset", spi_sdo, 0);
    chk("R1 cmd_valid after reset", cmd_valid, 0);
    chk("R1 fields after reset", {cmd_pad, cmd_op, cmd_tail}, 0);
    rst_n = 1'b1;
    idle_check(4);

    // R1: held word is zero before any load
    fill(128'hC3A5_0F96_0000_0000_0000_0000_0000_0000, 24);
    frame(2'b00, 24, -1, '0, "R1 zero held word");

    load(40'hA5_3C96_E17B);
    fill(128'h005A_F1C0_0000_0000_0000_0000_0000_0000, 24);
    frame(2'b00, 24, -1, '0, "R3 own bit 24");

    fill(128'h7E81_24DB_0000_0000_0000_0000_0000_0000, 32);
    frame(2'b01, 32, -1, '0, "R2 R3 own bit 32");

    fill(128'hFF12_3456_789A_0000_0000_0000_0000_0000, 40);
    frame(2'b10, 40, -1, '0, "R2 R3 own bit 40");

    // R2: alias code 2'b11 behaves as 24 bits
    fill(128'h3C69_9600_0000_0000_0000_0000_0000_0000, 24);
    frame(2'b11, 24, -1, '0, "R2 alias own bit");

    // R4 R8: three-device chain, 72 clocks
    fill(128'hDEAD_BEEF_0123_4567_89AB_0000_0000_0000, 72);
    frame(2'b00, 72, -1, '0, "R3 chain own bit");

    // R7: incomplete frame
    fill(128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 16);
    frame(2'b01, 16, -1, '0, "R3 short own bit");

    // R9: load during a frame is ignored (this and the next frame keep the old word)
    fill(128'h1357_9BDF_2468_0000_0000_0000_0000_0000, 40);
    frame(2'b10, 40, 10, 40'h11_2233_4455, "R9 word during load");
    fill(128'hACE1_2B3D_4F50_0000_0000_0000_0000_0000, 40);
    frame(2'b10, 40, -1, '0, "R9 word after ignored load");

    load(40'h0F_F00F_5AA5);
    fill(128'h9182_7364_5500_0000_0000_0000_0000_0000, 40);
    frame(2'b01, 40, -1, '0, "R9 new word");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule